// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block converts a 16-bit segment:offset reference into a 20-bit physical byte address for a processor that keeps four segment registers: extra, code, stack and data. The caller presents a reference kind together with an offset and an optional segment override. The block chooses the segment register from the reference kind and applies the override only where the rules allow it. It then adds the segment value shifted left by four to the offset. The segment registers are held inside the block and are loaded through a simple write port.

Reset leaves the code segment at all ones and the other segments at zero, so the first instruction fetch at offset zero lands at FFFF0h. A separate reference kind generates addresses in the interrupt pointer table at the bottom of memory. The bus is 8 bits wide, so a word reference is issued as two byte cycles in a fixed order: the low byte at the base address first, then the high byte at the next address. The block holds `busy` until the last byte cycle has been issued.

Top module: `segAddrGen`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. A sum that passes FFFFFh wraps around to the bottom of memory.
- R2: reqKind 0 (instruction fetch) always uses the code segment (select code 1), and any override is ignored.
- R3: reqKind 1 (stack push/pop) always uses the stack segment (select code 2), and any override is ignored.
- R4: reqKind 2 (BP-relative data) uses the stack segment by default. When reqOvrEn is 1, it uses the segment named by reqOvrSel (0 extra, 1 code, 2 stack, 3 data).
- R5: reqKind 3 (general data) and the unused codes 6 and 7 use the data segment (select code 3) by default. When reqOvrEn is 1, they use the segment named by reqOvrSel.
- R6: reqKind 4 (string destination) always uses the extra segment (select code 0), and any override is ignored.
- R7: After reset, busValid and busy are 0. The code segment holds FFFFh and the other three segments hold 0000h, so a fetch at offset 0 produces FFFF0h.
- R8: reqKind 5 (interrupt pointer) produces the address n×4 + 2×p, where n = reqOffset[7:0] and p = reqOffset[8]. p = 0 selects the offset word and p = 1 selects the segment word. No segment register is involved.
- R9: An accepted word request (reqWord = 1) produces two consecutive cycles with busValid = 1. The first has busHigh = 0 and the base address. The second has busHigh = 1 and the base address + 1, modulo 2^20.
- R10: An accepted byte request (reqWord = 0) produces exactly one busValid cycle, with busHigh = 0.
- R11: A request is accepted at a clock edge where reqValid = 1 and busy = 0. busy is 1 in every byte cycle of that transfer and returns to 0 after the last one. Requests presented while busy is 1 are ignored.
- R12: A write with segWrEn = 1 changes only the register named by segWrSel, and later references use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| segWrEn | input | 1 | Load a segment register |
| segWrSel | input | 2 | Register to load (0 extra, 1 code, 2 stack, 3 data) |
| segWrData | input | 16 | Value to load |
| reqValid | input | 1 | Reference request |
| reqKind | input | 3 | Reference kind (0 fetch, 1 stack, 2 BP-relative, 3 data, 4 string destination, 5 interrupt pointer) |
| reqOvrEn | input | 1 | Segment override present |
| reqOvrSel | input | 2 | Segment named by the override |
| reqOffset | input | 16 | Offset; for kind 5, bits 7:0 give the vector and bit 8 gives the word |
| reqWord | input | 1 | 1 for a 16-bit transfer, 0 for a single byte |
| busValid | output | 1 | A byte bus cycle is presented |
| busAddr | output | 20 | Physical byte address of the cycle |
| busHigh | output | 1 | The cycle carries the high byte of a word |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench builds the block with its default widths: 16-bit segments and offsets and a 20-bit address. At these widths every wrap and boundary case can be reached directly: a segment of FFFFh plus a large offset, and a word whose low byte sits at FFFFFh so that its high byte wraps to 00000h. The same widths also reach the top vector, 255, with both its words. Random kinds, overrides, offsets and segment loads exercise every selection rule against a shadow copy of the four registers kept in the bench.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

  localparam int NUM_SEGS = 4;

  localparam logic [1:0] SEG_EXTRA = 2'd0;
  localparam logic [1:0] SEG_CODE  = 2'd1;
  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_DATA  = 2'd3;

  localparam logic [2:0] KIND_FETCH  = 3'd0;
  localparam logic [2:0] KIND_STACK  = 3'd1;
  localparam logic [2:0] KIND_BPREL  = 3'd2;
  localparam logic [2:0] KIND_DATA   = 3'd3;
  localparam logic [2:0] KIND_STRDST = 3'd4;
  localparam logic [2:0] KIND_VECTOR = 3'd5;

  typedef struct packed {
    logic capture;   // latch a freshly formed base address
    logic advance;   // step to the high byte of a word
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } busState_t;

endpackage

// File: rtl/segaddr_dp.sv
module segaddr_dp
  import segaddr_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic [2:0]        reqKind,
  input  logic              reqOvrEn,
  input  logic [1:0]        reqOvrSel,
  input  logic [OFF_W-1:0]  reqOffset,
  input  ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int SHIFT   = ADDR_W - SEG_W;
  localparam int VEC_W   = 8;
  localparam int VADDR_W = VEC_W + 2;

  logic [SEG_W-1:0]  segReg [NUM_SEGS];
  logic [1:0]        segIdx;
  logic [SEG_W-1:0]  segVal;
  logic [ADDR_W-1:0] segExt;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] vecAddr;
  logic [ADDR_W-1:0] baseNext;
  logic [ADDR_W-1:0] addrReg;

  // segment register file; code segment comes out of reset at all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEGS; i++)
        segReg[i] <= (i == int'(SEG_CODE)) ? {SEG_W{1'b1}} : '0;
    end else if (segWrEn) begin
      segReg[segWrSel] <= segWrData;
    end
  end

  // default segment rules, override only where permitted
  always_comb begin
    case (reqKind)
      KIND_FETCH:  segIdx = SEG_CODE;
      KIND_STACK:  segIdx = SEG_STACK;
      KIND_BPREL:  segIdx = reqOvrEn ? reqOvrSel : SEG_STACK;
      KIND_STRDST: segIdx = SEG_EXTRA;
      default:     segIdx = reqOvrEn ? reqOvrSel : SEG_DATA;
    endcase
  end

  assign segVal  = segReg[segIdx];
  assign segExt  = ADDR_W'(segVal) << SHIFT;
  assign offExt  = ADDR_W'(reqOffset);
  assign vecAddr = ADDR_W'({reqOffset[VEC_W-1:0], reqOffset[VEC_W], 1'b0});

  generate
    if (VADDR_W <= ADDR_W) begin : gVecFits
      assign baseNext = (reqKind == KIND_VECTOR) ? vecAddr : (segExt + offExt);
    end else begin : gVecNone
      assign baseNext = segExt + offExt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrReg <= '0;
    else if (strobe.capture) addrReg <= baseNext;
    else if (strobe.advance) addrReg <= addrReg + 1'b1;
  end

  assign addrOut = addrReg;

  // R12: a load touches only the selected register
  a_r12_write_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && segWrSel != SEG_DATA) |=> segReg[SEG_DATA] == $past(segReg[SEG_DATA]));

  // R2: a captured fetch address is the code segment plus the offset
  a_r2_fetch_code: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && reqKind == KIND_FETCH && !segWrEn) |=>
      addrReg == ADDR_W'((ADDR_W'($past(segReg[SEG_CODE])) << SHIFT) + ADDR_W'($past(reqOffset))));

endmodule

// File: rtl/segaddr_ctrl.sv
module segaddr_ctrl
  import segaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWord,
  output ctrlStrobe_t strobe,
  output logic        busValid,
  output logic        busHigh,
  output logic        busy
);

  busState_t state, stateNext;
  logic      wordReg;
  logic      accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) stateNext = ST_LOW;
      ST_LOW:  stateNext = wordReg ? ST_HIGH : ST_IDLE;
      ST_HIGH: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) wordReg <= reqWord;
    end
  end

  assign strobe.capture = accept;
  assign strobe.advance = (state == ST_LOW) && wordReg;
  assign busValid       = (state != ST_IDLE);
  assign busHigh        = (state == ST_HIGH);
  assign busy           = (state != ST_IDLE);

  // R9: the high byte follows the low byte of a word
  a_r9_high_follows_low: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busHigh && wordReg) |=> (busValid && busHigh));

  // R10: a byte transfer lasts one cycle
  a_r10_byte_single: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busHigh && !wordReg) |=> !busValid);

  // R11: a high byte is never issued without a low byte just before it
  a_r11_high_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busHigh) |-> $past(busValid && !busHigh));

endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segaddr_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic              reqOvrEn,
  input  logic [1:0]        reqOvrSel,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              reqWord,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busHigh,
  output logic              busy
);

  ctrlStrobe_t strobe;

  segaddr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWord  (reqWord),
    .strobe   (strobe),
    .busValid (busValid),
    .busHigh  (busHigh),
    .busy     (busy)
  );

  segaddr_dp #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .ADDR_W (ADDR_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .segWrEn   (segWrEn),
    .segWrSel  (segWrSel),
    .segWrData (segWrData),
    .reqKind   (reqKind),
    .reqOvrEn  (reqOvrEn),
    .reqOvrSel (reqOvrSel),
    .reqOffset (reqOffset),
    .strobe    (strobe),
    .addrOut   (busAddr)
  );

  // R9: the high byte address is the low byte address plus one, wrapping
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busHigh) |-> busAddr == ADDR_W'($past(busAddr) + 1'b1));

  // R11: busy covers every presented bus cycle
  a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busy);

endmodule

// File: tb/segAddrGen_test.sv
module segAddrGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = '0;
  logic        reqOvrEn = 1'b0;
  logic [1:0]  reqOvrSel = '0;
  logic [15:0] reqOffset = '0;
  logic        reqWord = 1'b0;
  logic        busValid;
  logic [19:0] busAddr;
  logic        busHigh;
  logic        busy;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic [15:0] shadow [4];

  always #2 clk = ~clk;

  segAddrGen uut (
    .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segWrSel(segWrSel),
    .segWrData(segWrData), .reqValid(reqValid), .reqKind(reqKind),
    .reqOvrEn(reqOvrEn), .reqOvrSel(reqOvrSel), .reqOffset(reqOffset),
    .reqWord(reqWord), .busValid(busValid), .busAddr(busAddr),
    .busHigh(busHigh), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R6";
      3'd5: return "R8";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [19:0] expAddr(input logic [2:0] k, input logic ov,
                                          input logic [1:0] os, input logic [15:0] off);
    logic [1:0] s;
    if (k == 3'd5) return {10'd0, off[7:0], off[8], 1'b0};
    case (k)
      3'd0: s = 2'd1;
      3'd1: s = 2'd2;
      3'd2: s = ov ? os : 2'd2;
      3'd4: s = 2'd0;
      default: s = ov ? os : 2'd3;
    endcase
    return 20'({shadow[s], 4'h0} + {4'h0, off});
  endfunction

  task automatic writeSeg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrSel = sel; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
    shadow[sel] = val;
  endtask

  // issue one request and check every byte cycle; holdBusy keeps reqValid
  // high with a different offset while the transfer is in progress
  task automatic issue(input logic [2:0] k, input logic ov, input logic [1:0] os,
                       input logic [15:0] off, input logic wd, input bit holdBusy);
    logic [19:0] e;
    e = expAddr(k, ov, os, off);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqOvrEn = ov; reqOvrSel = os;
    reqOffset = off; reqWord = wd;
    @(negedge clk);
    if (holdBusy) reqOffset = off ^ 16'h5A5A;
    else reqValid = 1'b0;
    check(busValid && !busHigh && busy && busAddr == e, tagOf(k),
          {busValid, busHigh, busy, 9'd0, busAddr}, {3'b101, 9'd0, e});
    if (wd) begin
      @(negedge clk);
      if (holdBusy) reqValid = 1'b0;
      check(busValid && busHigh && busy && busAddr == 20'(e + 1), "R9",
            {busValid, busHigh, busy, 9'd0, busAddr}, {3'b111, 9'd0, 20'(e + 1)});
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(!busValid && !busy, wd ? (holdBusy ? "R11" : "R9") : "R10",
          {30'd0, busValid, busy}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog actual=running expected=done");
    if (!finished) begin
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    shadow[0] = 16'h0000; shadow[1] = 16'hFFFF; shadow[2] = 16'h0000; shadow[3] = 16'h0000;
    repeat (3) @(negedge clk);
    check(!busValid && !busy, "R7", {30'd0, busValid, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busValid && !busy, "R7", {30'd0, busValid, busy}, 32'd0);

    // R7: first fetch lands at FFFF0h
    issue(3'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 0);
    // R2: override on fetch ignored
    issue(3'd0, 1'b1, 2'd3, 16'h0010, 1'b0, 0);
    // R1: wrap past the top of memory
    writeSeg(2'd3, 16'hFFFF);
    issue(3'd3, 1'b0, 2'd0, 16'hFFFF, 1'b0, 0);
    // R9: word whose high byte wraps to 00000h
    writeSeg(2'd3, 16'hF000);
    issue(3'd3, 1'b0, 2'd0, 16'hFFFF, 1'b1, 0);
    // R12: data write leaves extra segment alone
    writeSeg(2'd0, 16'h1234);
    writeSeg(2'd3, 16'h4321);
    issue(3'd4, 1'b0, 2'd0, 16'h0002, 1'b0, 0);
    issue(3'd3, 1'b0, 2'd0, 16'h0002, 1'b0, 0);
    // R4 / R5: overrides honoured
    writeSeg(2'd2, 16'h2000);
    issue(3'd2, 1'b0, 2'd0, 16'h0100, 1'b1, 0);
    issue(3'd2, 1'b1, 2'd0, 16'h0100, 1'b1, 0);
    issue(3'd3, 1'b1, 2'd1, 16'h0100, 1'b0, 0);
    // R3 / R6: overrides ignored
    issue(3'd1, 1'b1, 2'd3, 16'hFFFE, 1'b1, 0);
    issue(3'd4, 1'b1, 2'd2, 16'h0040, 1'b1, 0);
    // R8: vector 0 and vector 255 both words
    issue(3'd5, 1'b0, 2'd0, 16'h0000, 1'b1, 0);
    issue(3'd5, 1'b0, 2'd0, 16'h00FF, 1'b1, 0);
    issue(3'd5, 1'b1, 2'd3, 16'h01FF, 1'b1, 0);
    // R11: request held during busy is not taken again mid-transfer
    issue(3'd3, 1'b0, 2'd0, 16'h0800, 1'b1, 1);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 4) == 0)
        writeSeg(2'($urandom_range(0, 3)), 16'($urandom));
      issue(3'($urandom_range(0, 5)), 1'($urandom), 2'($urandom_range(0, 3)),
            16'($urandom), 1'($urandom), 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule